// File: doc/BRIEF.md
# Reset-Time Subsystem ID Autoload Controller

This block runs once after the active-low reset is released. It reads three consecutive 16-bit words from a serial configuration EEPROM over a four-wire Microwire-style link. The words sit at word addresses 0Ah, 0Bh and 0Ch. The first word is a control word: its top two bits carry a signature and bit 13 enables the ID overrides. The other two words hold the Subsystem ID and the Subsystem Vendor ID. From these values the block sets the identity fields that a small configuration-space read port returns.

While the load is still in progress, every configuration read request is refused with a Retry indication. Once all three words have been read, a sticky done flag opens the read port until the next reset. From then on the port returns the latched IDs, the fixed Device/Vendor IDs, the class/revision dword, the capability pointer and the interrupt pin.

Top module: `id_autoload_top`

## Requirements
- R1: After reset release the block reads words 0Ah, 0Bh and 0Ch in that order. Each read sends, MSB first on `ee_di_o`, a start bit 1, then opcode bits 10, then the 6-bit word address. `ee_cs_o` is low between words and stays low for at least one serial clock period.
- R2: `ee_sk_o` has a period of 2*CLK_DIV system clocks. After the address, one dummy bit is skipped. The 16 data bits are then taken MSB first from `ee_do_i` on rising edges of `ee_sk_o`.
- R3: Until `load_done_o` is 1, a request on `cfg_req_i` gives `cfg_retry_o`=1 and `cfg_ack_o`=0 in the next cycle.
- R4: A control word whose bits 15:14 are not 01b (11b, 10b or 00b) is invalid. In that case Subsystem ID and Subsystem Vendor ID read 0000h and the revision reads 0Fh, whatever bit 13 holds.
- R5: With signature 01b and bit 13 = 1, the Subsystem ID takes word 0Bh and the Subsystem Vendor ID takes word 0Ch.
- R6: With signature 01b and bit 13 = 1, revision bits 2:0 take control-word bits 10:8. Revision bits 7:3 keep the default, so the revision becomes 08h plus those three bits.
- R7: With signature 01b and bit 13 = 0, both subsystem fields read 0000h and the revision reads 0Fh.
- R8: Dword 00h reads {DEVICE_ID, VENDOR_ID} (Device ID in bits 31:16) for every EEPROM content.
- R9: Dword 0Dh reads 000000DCh (capability pointer). Dword 0Fh reads 00000100h (interrupt pin 01h in bits 15:8, interrupt line 00h).
- R10: After the load, a request gives `cfg_ack_o`=1 and `cfg_retry_o`=0 in the next cycle. `load_done_o` stays 1 and `ee_cs_o` stays 0 until the next reset.
- R11: Dword 02h reads {CLASS_CODE, revision} and dword 0Bh reads {Subsystem ID, Subsystem Vendor ID}. Any other dword index reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release starts the load |
| ee_cs_o | output | 1 | EEPROM chip select, active high |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial command/address data to the EEPROM |
| ee_do_i | input | 1 | Serial read data from the EEPROM |
| cfg_req_i | input | 1 | Configuration read request, one cycle |
| cfg_addr_i | input | 6 | Configuration dword index |
| cfg_rdata_o | output | 32 | Read data, valid with cfg_ack_o |
| cfg_ack_o | output | 1 | Request completed, one cycle after the request |
| cfg_retry_o | output | 1 | Request refused because the load is not done |
| load_done_o | output | 1 | Sticky flag: autoload finished |

## Verification
The bench walks every signature code with bit 13 both set and clear. It uses asymmetric data words, so a design that drops the enable check, treats 11b as valid, swaps the two subsystem words, or shifts in the dummy bit as data returns visibly wrong IDs. A request issued a few cycles after reset release catches a design that acknowledges before the load ends. A reset in the middle of a word catches a sequencer that resumes at the wrong address or keeps stale values. Revision values 08h and 0Fh at the edges of the three-bit field, and a long idle stretch after the load, show whether the revision merge is wrong and whether the done flag or chip select ever toggles again.

// File: rtl/id_autoload_pkg.sv
package id_autoload_pkg;
  localparam int WORD_W     = 16;
  localparam int EE_ADDR_W  = 6;
  localparam int HDR_W      = 3;
  localparam int CMD_W      = HDR_W + EE_ADDR_W;
  localparam int DUMMY_BITS = 1;
  localparam int XFER_BITS  = CMD_W + DUMMY_BITS + WORD_W;
  localparam logic [HDR_W-1:0] MW_READ_HDR = 3'b110;  // start bit + read opcode
  localparam logic [1:0]       SIG_OK      = 2'b01;

  typedef enum logic [1:0] {
    W_CTRL  = 2'd0,
    W_SSID  = 2'd1,
    W_SSVID = 2'd2
  } word_sel_e;
endpackage

// File: rtl/mw_sk_gen.sv
module mw_sk_gen #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          sk_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(DIV - 1));
  assign rise_o = run_i & wrap & ~sk_q;
  assign fall_o = run_i & wrap &  sk_q;
  assign sk_o   = sk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sk_q  <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sk_q  <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      sk_q  <= ~sk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_sk_rise_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sk_o) |-> $past(rise_o));
  p_sk_idle_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !sk_o);
endmodule

// File: rtl/mw_word_reader.sv
module mw_word_reader
  import id_autoload_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [EE_ADDR_W-1:0] addr_i,
  output logic                 idle_o,
  output logic                 valid_o,
  output logic [WORD_W-1:0]    word_o,
  output logic                 cs_o,
  output logic                 sk_o,
  output logic                 di_o,
  input  logic                 do_i
);
  localparam int GAP_CYC = 2 * CLK_DIV;
  localparam int GW      = $clog2(GAP_CYC + 1);
  localparam int BW      = $clog2(XFER_BITS + 1);
  localparam int DATA_AT = CMD_W + DUMMY_BITS;

  typedef enum logic [1:0] {RD_IDLE, RD_XFER, RD_GAP} rd_state_e;

  rd_state_e         state_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [WORD_W-1:0] data_q;
  logic [BW-1:0]     bit_q;
  logic [GW-1:0]     gap_q;
  logic              cs_q, valid_q;
  logic              rise, fall;

  mw_sk_gen #(.DIV(CLK_DIV)) u_sk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == RD_XFER),
    .sk_o   (sk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign idle_o  = (state_q == RD_IDLE);
  assign valid_o = valid_q;
  assign word_o  = data_q;
  assign cs_o    = cs_q;
  assign di_o    = cs_q & cmd_q[CMD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_IDLE;
      cmd_q   <= '0;
      data_q  <= '0;
      bit_q   <= '0;
      gap_q   <= '0;
      cs_q    <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        RD_IDLE: if (start_i) begin
          state_q <= RD_XFER;
          cs_q    <= 1'b1;
          cmd_q   <= {MW_READ_HDR, addr_i};
          bit_q   <= '0;
        end
        RD_XFER: begin
          if (fall) cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
          if (rise) begin
            bit_q <= bit_q + 1'b1;
            if (bit_q >= BW'(DATA_AT)) data_q <= {data_q[WORD_W-2:0], do_i};
            if (bit_q == BW'(XFER_BITS - 1)) begin
              state_q <= RD_GAP;
              cs_q    <= 1'b0;
              valid_q <= 1'b1;
              gap_q   <= '0;
            end
          end
        end
        RD_GAP: begin
          gap_q <= gap_q + 1'b1;
          if (gap_q == GW'(GAP_CYC - 1)) state_q <= RD_IDLE;
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  p_cs_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |=> !cs_o);
  p_valid_ends_word_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (!cs_o && $past(cs_o)));
  p_no_sk_without_cs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |=> !sk_o);
endmodule

// File: rtl/id_field_regs.sv
module id_field_regs
  import id_autoload_pkg::*;
#(
  parameter logic [7:0] REV_DEFAULT = 8'h0F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  word_sel_e         wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] ssid_o,
  output logic [WORD_W-1:0] ssvid_o,
  output logic [7:0]        rev_o
);
  localparam int SIG_HI = 15;
  localparam int SIG_LO = 14;
  localparam int EN_BIT = 13;
  localparam int REV_HI = 10;
  localparam int REV_LO = 8;
  localparam int REV_W  = REV_HI - REV_LO + 1;

  logic ovr_q;
  logic ctrl_ok;

  assign ctrl_ok = (wr_data_i[SIG_HI:SIG_LO] == SIG_OK) & wr_data_i[EN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q   <= 1'b0;
      ssid_o  <= '0;
      ssvid_o <= '0;
      rev_o   <= REV_DEFAULT;
    end else if (wr_en_i) begin
      unique case (wr_sel_i)
        W_CTRL: begin
          ovr_q <= ctrl_ok;
          rev_o <= ctrl_ok ? {REV_DEFAULT[7:REV_W], wr_data_i[REV_HI:REV_LO]} : REV_DEFAULT;
        end
        W_SSID:  if (ovr_q) ssid_o  <= wr_data_i;
        W_SSVID: if (ovr_q) ssvid_o <= wr_data_i;
        default: ;
      endcase
    end
  end

  p_bad_sig_rev_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == W_CTRL && wr_data_i[SIG_HI:SIG_LO] != SIG_OK) |=> rev_o == REV_DEFAULT);
  p_ssid_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == W_SSID && ovr_q) |=> ssid_o == $past(wr_data_i));
  p_ssid_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == W_SSID && !ovr_q) |=> $stable(ssid_o));
  p_ssvid_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == W_SSVID && !ovr_q) |=> $stable(ssvid_o));
  p_rev_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rev_o[7:REV_W] == REV_DEFAULT[7:REV_W]);
endmodule

// File: rtl/id_autoload_top.sv
module id_autoload_top
  import id_autoload_pkg::*;
#(
  parameter int                 CLK_DIV     = 4,
  parameter logic [EE_ADDR_W-1:0] EE_BASE   = 6'h0A,
  parameter logic [15:0]        DEVICE_ID   = 16'h0D10,
  parameter logic [15:0]        VENDOR_ID   = 16'h1F2E,
  parameter logic [7:0]         REV_DEFAULT = 8'h0F,
  parameter logic [23:0]        CLASS_CODE  = 24'h020000,
  parameter logic [7:0]         CAP_PTR     = 8'hDC,
  parameter logic [7:0]         INT_PIN     = 8'h01
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic        ee_cs_o,
  output logic        ee_sk_o,
  output logic        ee_di_o,
  input  logic        ee_do_i,
  input  logic        cfg_req_i,
  input  logic [5:0]  cfg_addr_i,
  output logic [31:0] cfg_rdata_o,
  output logic        cfg_ack_o,
  output logic        cfg_retry_o,
  output logic        load_done_o
);
  localparam int        NWORDS    = 3;
  localparam logic [5:0] DW_ID     = 6'h00;
  localparam logic [5:0] DW_CLASS  = 6'h02;
  localparam logic [5:0] DW_SUBSYS = 6'h0B;
  localparam logic [5:0] DW_CAP    = 6'h0D;
  localparam logic [5:0] DW_INT    = 6'h0F;

  word_sel_e         idx_q;
  logic              inflight_q, done_q;
  logic              rd_idle, rd_valid, start;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] ssid, ssvid;
  logic [7:0]        rev;
  logic [31:0]       mux_data;

  assign start = ~done_q & ~inflight_q;

  mw_word_reader #(.CLK_DIV(CLK_DIV)) u_reader (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .addr_i  (EE_BASE + EE_ADDR_W'(idx_q)),
    .idle_o  (rd_idle),
    .valid_o (rd_valid),
    .word_o  (rd_word),
    .cs_o    (ee_cs_o),
    .sk_o    (ee_sk_o),
    .di_o    (ee_di_o),
    .do_i    (ee_do_i)
  );

  id_field_regs #(.REV_DEFAULT(REV_DEFAULT)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (rd_valid),
    .wr_sel_i  (idx_q),
    .wr_data_i (rd_word),
    .ssid_o    (ssid),
    .ssvid_o   (ssvid),
    .rev_o     (rev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q      <= W_CTRL;
      inflight_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      if (start && rd_idle) inflight_q <= 1'b1;
      if (rd_valid) begin
        inflight_q <= 1'b0;
        if (idx_q == word_sel_e'(NWORDS - 1)) done_q <= 1'b1;
        else idx_q <= word_sel_e'(idx_q + 2'd1);
      end
    end
  end

  always_comb begin
    unique case (cfg_addr_i)
      DW_ID:     mux_data = {DEVICE_ID, VENDOR_ID};
      DW_CLASS:  mux_data = {CLASS_CODE, rev};
      DW_SUBSYS: mux_data = {ssid, ssvid};
      DW_CAP:    mux_data = {24'h0, CAP_PTR};
      DW_INT:    mux_data = {16'h0, INT_PIN, 8'h00};
      default:   mux_data = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_ack_o   <= 1'b0;
      cfg_retry_o <= 1'b0;
      cfg_rdata_o <= '0;
    end else begin
      cfg_ack_o   <= cfg_req_i &  done_q;
      cfg_retry_o <= cfg_req_i & ~done_q;
      cfg_rdata_o <= (cfg_req_i & done_q) ? mux_data : '0;
    end
  end

  assign load_done_o = done_q;

  p_retry_before_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_i && !load_done_o) |=> (cfg_retry_o && !cfg_ack_o));
  p_ack_after_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_i && load_done_o) |=> (cfg_ack_o && !cfg_retry_o));
  p_done_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_done_o |=> load_done_o);
  p_quiet_after_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_done_o |-> !ee_cs_o);
  p_resp_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cfg_ack_o, cfg_retry_o}));
endmodule

// File: tb/id_autoload_top_tb.sv
module id_autoload_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam logic [15:0] DEV = 16'h0D10;
  localparam logic [15:0] VEN = 16'h1F2E;

  typedef struct packed {
    logic [15:0] ctrl;
    logic [15:0] w_ssid;
    logic [15:0] w_ssvid;
    logic [15:0] e_ssid;
    logic [15:0] e_ssvid;
    logic [7:0]  e_rev;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'h6500, 16'h1234, 16'hABCD, 16'h1234, 16'hABCD, 8'h0D},  // R5 R6 valid+en
    '{16'h4700, 16'h1234, 16'hABCD, 16'h0000, 16'h0000, 8'h0F},  // R7 valid, en=0
    '{16'hE300, 16'h5555, 16'hAAAA, 16'h0000, 16'h0000, 8'h0F},  // R4 sig 11
    '{16'hA000, 16'h5555, 16'hAAAA, 16'h0000, 16'h0000, 8'h0F},  // R4 sig 10
    '{16'h2000, 16'h5555, 16'hAAAA, 16'h0000, 16'h0000, 8'h0F},  // R4 sig 00
    '{16'h6000, 16'hFFFF, 16'h0001, 16'hFFFF, 16'h0001, 8'h08},  // R6 low edge
    '{16'h7FFF, 16'h8000, 16'h7FFE, 16'h8000, 16'h7FFE, 8'h0F}   // R6 high edge
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ee_cs, ee_sk, ee_di;
  logic ee_do = 1'b1;
  logic cfg_req = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [31:0] cfg_rdata;
  logic cfg_ack, cfg_retry, load_done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  id_autoload_top #(.CLK_DIV(DIV), .DEVICE_ID(DEV), .VENDOR_ID(VEN)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ee_cs_o     (ee_cs),
    .ee_sk_o     (ee_sk),
    .ee_di_o     (ee_di),
    .ee_do_i     (ee_do),
    .cfg_req_i   (cfg_req),
    .cfg_addr_i  (cfg_addr),
    .cfg_rdata_o (cfg_rdata),
    .cfg_ack_o   (cfg_ack),
    .cfg_retry_o (cfg_retry),
    .load_done_o (load_done)
  );

  // serial EEPROM model
  logic [15:0] ee_mem [3];
  int          rcnt = 0;
  logic [8:0]  cmd = '0;
  logic [5:0]  cur_addr = '0;
  int          word_cnt = 0;
  logic [5:0]  addr_log [64];
  logic [2:0]  hdr_log  [64];

  function automatic logic [15:0] mem_rd(logic [5:0] a);
    if (a >= 6'h0A && a <= 6'h0C) return ee_mem[int'(a) - 10];
    return 16'h0000;
  endfunction

  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      rcnt = 0;
      cmd  = '0;
    end else begin
      if (rcnt < 9) cmd = {cmd[7:0], ee_di};
      rcnt = rcnt + 1;
    end
  end

  always @(negedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) ee_do = 1'b1;
    else if (rcnt == 9) begin
      ee_do    = 1'b0;
      cur_addr = cmd[5:0];
      addr_log[word_cnt % 64] = cmd[5:0];
      hdr_log[word_cnt % 64]  = cmd[8:6];
      word_cnt = word_cnt + 1;
    end else if (rcnt >= 10 && rcnt <= 25) begin
      logic [15:0] w;
      w = mem_rd(cur_addr);
      ee_do = w[15 - (rcnt - 10)];
    end else ee_do = 1'b1;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_read(logic [5:0] a, output logic [31:0] d, output logic ack, output logic rty);
    @(negedge clk);
    cfg_req  = 1'b1;
    cfg_addr = a;
    @(negedge clk);
    cfg_req  = 1'b0;
    d   = cfg_rdata;
    ack = cfg_ack;
    rty = cfg_retry;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done(string req);
    int n = 0;
    while (!load_done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(req, {31'b0, load_done}, 32'd1);
  endtask

  task automatic set_mem(vec_t v);
    ee_mem[0] = v.ctrl;
    ee_mem[1] = v.w_ssid;
    ee_mem[2] = v.w_ssvid;
  endtask

  task automatic chk_addrs(int base);
    chk("R1 word count", 32'(word_cnt - base), 32'd3);
    for (int k = 0; k < 3; k++) begin
      chk("R1 address order", {26'b0, addr_log[(base + k) % 64]}, 32'(10 + k));
      chk("R1 start+opcode", {29'b0, hdr_log[(base + k) % 64]}, 32'b110);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic ack, rty;
    int base;

    repeat (3) @(negedge clk);
    chk("R1 reset cs", {31'b0, ee_cs}, 32'd0);
    chk("R2 reset sk", {31'b0, ee_sk}, 32'd0);
    chk("R10 reset done", {31'b0, load_done}, 32'd0);
    chk("R3 reset ack", {31'b0, cfg_ack}, 32'd0);
    chk("R3 reset retry", {31'b0, cfg_retry}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      set_mem(VECS[i]);
      base = word_cnt;
      do_reset();
      cfg_read(6'h0B, d, ack, rty);
      chk("R3 early retry", {31'b0, rty}, 32'd1);
      chk("R3 early no ack", {31'b0, ack}, 32'd0);
      if (i == 0) begin
        int idx = 0;
        int r0 = -1;
        int r1 = -1;
        logic prev = ee_sk;
        while (r1 < 0 && idx < 200) begin
          @(negedge clk);
          idx++;
          if (ee_sk && !prev) begin
            if (r0 < 0) r0 = idx; else r1 = idx;
          end
          prev = ee_sk;
        end
        chk("R2 sk period", 32'(r1 - r0), 32'(2 * DIV));
      end
      wait_done("R10 load completes");
      chk_addrs(base);
      cfg_read(6'h0B, d, ack, rty);
      chk("R10 ack after load", {30'b0, ack, rty}, 32'b10);
      chk("R5 R4 R7 R2 subsystem dword", d, {VECS[i].e_ssid, VECS[i].e_ssvid});
      cfg_read(6'h02, d, ack, rty);
      chk("R6 R11 class/rev dword", d, {24'h020000, VECS[i].e_rev});
    end

    cfg_read(6'h00, d, ack, rty);
    chk("R8 device/vendor", d, {DEV, VEN});
    cfg_read(6'h0D, d, ack, rty);
    chk("R9 cap pointer", d, 32'h0000_00DC);
    cfg_read(6'h0F, d, ack, rty);
    chk("R9 interrupt pin", d, 32'h0000_0100);
    cfg_read(6'h05, d, ack, rty);
    chk("R11 unused dword", d, 32'h0);
    cfg_read(6'h3F, d, ack, rty);
    chk("R11 top dword", d, 32'h0);

    base = word_cnt;
    repeat (300) @(negedge clk);
    chk("R10 done sticky", {31'b0, load_done}, 32'd1);
    chk("R10 no EEPROM traffic", 32'(word_cnt - base), 32'd0);
    chk("R10 cs idle", {31'b0, ee_cs}, 32'd0);

    // reset in the middle of a word, then a clean reload
    set_mem(VECS[0]);
    do_reset();
    repeat (150) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 done cleared by reset", {31'b0, load_done}, 32'd0);
    chk("R1 cs low in reset", {31'b0, ee_cs}, 32'd0);
    set_mem(VECS[5]);
    base = word_cnt;
    @(negedge clk);
    rst_n = 1'b1;
    wait_done("R10 reload completes");
    chk_addrs(base);
    cfg_read(6'h0B, d, ack, rty);
    chk("R5 reload subsystem", d, {VECS[5].e_ssid, VECS[5].e_ssvid});
    cfg_read(6'h02, d, ack, rty);
    chk("R6 reload rev", d, {24'h020000, VECS[5].e_rev});

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule